// File: doc/BRIEF.md
# Envelope Rate Calculator

This block works out the effective envelope rate for a set of operator slots in a frequency-modulation synthesis voice engine. An internal sequencer visits the slots in strict round-robin order. It makes two visits in every update period, one at the start of the period and one exactly halfway through. On each visit the block presents the slot number and a register-bank address to the surrounding logic. In the same cycle it receives the slot's envelope phase, its keycode and the rate fields from the register file. It then registers a 6-bit effective rate for the envelope counter that sits downstream.

The base rate depends on the phase. Attack, decay and sustain each use a 5-bit rate field. Release uses a 4-bit field that is widened to an odd 5-bit value. A non-zero base rate is doubled, and a keycode term set by a 2-bit key-scale field is added to it. The sum saturates at 63. A base rate of zero gives zero, with no key scaling.

The result leaves on a valid/ready stream. The result is held while ready is low, and it is taken on any cycle where valid and ready are both high. The visits follow a fixed schedule, so the stream cannot stall the sequencer. A result that has not been taken when the next visit arrives is replaced by the new one. The consumer must therefore accept a result within half an update period to see every slot.

Top module: `env_rate_calc`

## Requirements
- R1: After reset, `rate_valid_o` is 0, `slot_o` is 0 and `bank_o` is 0. The first visit happens on the first rising edge with reset released, so a result is valid in the next cycle.
- R2: Visits occur every PERIOD/2 = 72 cycles. Each visit raises `rate_valid_o` in the following cycle. With `rate_ready_i` held high, valid stays high for exactly one cycle.
- R3: Successive visits service slots 0, 1, …, 23 and then wrap to 0.
- R4: Slots 0–2 read bank 0 (`bank_o`=0) at index equal to the slot. Slots 3–23 read bank 1 (`bank_o`=1) at index slot−3.
- R5: The phase code is 0 = attack, 1 = decay, 2 = sustain, 3 = release. For codes 0, 1 and 2 the base rate is `atk_rate_i`, `dec_rate_i` or `sus_rate_i` respectively.
- R6: For phase code 3 the base rate is `{rel_rate_i, 1'b1}`: the 4-bit field is shifted left by one and its low bit is forced to 1.
- R7: The keycode term is `keycode_i >> (3 − ks_sel_i)`. Key-scale 0 shifts right by 3 and key-scale 3 does not shift.
- R8: For a non-zero base rate, the result is 2×base + keycode term.
- R9: The result saturates at 63.
- R10: A base rate of 0 gives a result of 0, whatever the keycode and key-scale.
- R11: While `rate_valid_o` is high and `rate_ready_i` is low, valid stays high and `rate_o` stays unchanged until the next visit. Valid falls in the cycle after a handshake.
- R12: A visit that finds a result not yet taken overwrites it with the new slot's result, and valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_o | output | 5 | Slot currently being serviced |
| bank_o | output | 1 | Register bank to read (0 = first bank) |
| reg_idx_o | output | 5 | Slot index within the selected bank |
| phase_i | input | 2 | Envelope phase of the current slot |
| keycode_i | input | 5 | Keycode of the channel that owns the slot |
| ks_sel_i | input | 2 | Key-scale field of the slot |
| atk_rate_i | input | 5 | Attack rate field |
| dec_rate_i | input | 5 | Decay rate field |
| sus_rate_i | input | 5 | Sustain rate field |
| rel_rate_i | input | 4 | Release rate field |
| rate_o | output | 6 | Effective envelope rate |
| rate_valid_o | output | 1 | Result valid |
| rate_ready_i | input | 1 | Consumer accepts the result |

## Verification
The hardest case to reach is a visit that lands on an unconsumed result. It needs ready held low for more than 72 cycles, and the overwritten value has to be told apart from the held one. The bench drops ready just after a handshake and holds it low through the hold window and into the next visit. It checks the stable value first and then the next slot's value, and only then releases ready. The crossing between the two banks is reached only by walking through slots 2 and 3. To cover it, the bench register model answers strictly by bank and index, and each slot is given distinct contents, so a wrong mapping returns another slot's fields.

// File: rtl/erc_pkg.sv
package erc_pkg;

  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_SUSTAIN = 2'd2,
    PH_RELEASE = 2'd3
  } env_phase_e;

endpackage

// File: rtl/erc_slot_seq.sv
module erc_slot_seq #(
  parameter int PERIOD      = 144,
  parameter int NUM_SLOTS   = 24,
  parameter int BANK0_SLOTS = 3,
  localparam int HALF   = PERIOD / 2,
  localparam int CYC_W  = $clog2(PERIOD),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              upd_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              bank_o,
  output logic [SLOT_W-1:0] idx_o
);

  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;

  // free-running position within one update period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q == CYC_W'(PERIOD - 1)) begin
      cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // two visits per period: at its start and at its midpoint
  assign upd_o = (cyc_q == '0) || (cyc_q == CYC_W'(HALF));

  // round-robin slot pointer, moves on after every visit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (upd_o) begin
      if (slot_q == SLOT_W'(NUM_SLOTS - 1)) slot_q <= '0;
      else                                  slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o = slot_q;

  generate
    if (BANK0_SLOTS > 0) begin : g_two_banks
      assign bank_o = (slot_q >= SLOT_W'(BANK0_SLOTS));
      assign idx_o  = bank_o ? (slot_q - SLOT_W'(BANK0_SLOTS)) : slot_q;
    end else begin : g_one_bank
      assign bank_o = 1'b1;
      assign idx_o  = slot_q;
    end
  endgenerate

endmodule

// File: rtl/erc_base_sel.sv
module erc_base_sel #(
  parameter int BASE_W = 5
) (
  input  logic [1:0]        phase_i,
  input  logic [BASE_W-1:0] atk_i,
  input  logic [BASE_W-1:0] dec_i,
  input  logic [BASE_W-1:0] sus_i,
  input  logic [BASE_W-2:0] rel_i,
  output logic [BASE_W-1:0] base_o
);
  import erc_pkg::*;

  env_phase_e ph;
  assign ph = env_phase_e'(phase_i);

  always_comb begin
    unique case (ph)
      PH_ATTACK:  base_o = atk_i;
      PH_DECAY:   base_o = dec_i;
      PH_SUSTAIN: base_o = sus_i;
      PH_RELEASE: base_o = {rel_i, 1'b1};  // widened release is always odd
      default:    base_o = '0;
    endcase
  end

endmodule

// File: rtl/erc_keyscale.sv
module erc_keyscale #(
  parameter int BASE_W = 5,
  parameter int KC_W   = 5,
  parameter int RATE_W = 6,
  localparam int WIDE   = (KC_W > BASE_W + 1) ? KC_W : BASE_W + 1,
  localparam int SUM_W  = WIDE + 1,
  localparam int RATE_MAX = (1 << RATE_W) - 1
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [1:0]        ks_sel_i,
  input  logic [KC_W-1:0]   kc_i,
  output logic [RATE_W-1:0] rate_o
);

  logic [SUM_W-1:0] dbl;
  logic [SUM_W-1:0] term;
  logic [SUM_W-1:0] sum;
  logic [KC_W-1:0]  kc_sh;

  // larger key-scale setting means less right shift of the keycode
  assign kc_sh = kc_i >> (2'd3 - ks_sel_i);
  assign dbl   = SUM_W'({base_i, 1'b0});
  assign term  = SUM_W'(kc_sh);
  assign sum   = dbl + term;

  always_comb begin
    if (base_i == '0) begin
      rate_o = '0;
    end else if (sum > SUM_W'(RATE_MAX)) begin
      rate_o = RATE_W'(RATE_MAX);
    end else begin
      rate_o = sum[RATE_W-1:0];
    end
  end

endmodule

// File: rtl/env_rate_calc.sv
module env_rate_calc #(
  parameter int PERIOD      = 144,
  parameter int NUM_SLOTS   = 24,
  parameter int BANK0_SLOTS = 3,
  parameter int BASE_W      = 5,
  parameter int KC_W        = 5,
  parameter int RATE_W      = 6,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o,
  output logic              bank_o,
  output logic [SLOT_W-1:0] reg_idx_o,
  input  logic [1:0]        phase_i,
  input  logic [KC_W-1:0]   keycode_i,
  input  logic [1:0]        ks_sel_i,
  input  logic [BASE_W-1:0] atk_rate_i,
  input  logic [BASE_W-1:0] dec_rate_i,
  input  logic [BASE_W-1:0] sus_rate_i,
  input  logic [BASE_W-2:0] rel_rate_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              rate_valid_o,
  input  logic              rate_ready_i
);

  logic              upd_w;
  logic [BASE_W-1:0] base_w;
  logic [RATE_W-1:0] eff_w;
  logic [RATE_W-1:0] rate_q;
  logic              valid_q;

  erc_slot_seq #(
    .PERIOD(PERIOD), .NUM_SLOTS(NUM_SLOTS), .BANK0_SLOTS(BANK0_SLOTS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .upd_o(upd_w),
    .slot_o(slot_o), .bank_o(bank_o), .idx_o(reg_idx_o)
  );

  erc_base_sel #(.BASE_W(BASE_W)) u_base (
    .phase_i(phase_i), .atk_i(atk_rate_i), .dec_i(dec_rate_i),
    .sus_i(sus_rate_i), .rel_i(rel_rate_i), .base_o(base_w)
  );

  erc_keyscale #(.BASE_W(BASE_W), .KC_W(KC_W), .RATE_W(RATE_W)) u_ks (
    .base_i(base_w), .ks_sel_i(ks_sel_i), .kc_i(keycode_i), .rate_o(eff_w)
  );

  // output stage: a visit always loads; otherwise hold until handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= '0;
      valid_q <= 1'b0;
    end else if (upd_w) begin
      rate_q  <= eff_w;
      valid_q <= 1'b1;
    end else if (valid_q && rate_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign rate_o       = rate_q;
  assign rate_valid_o = valid_q;

endmodule

// File: rtl/env_rate_calc_chk.sv
module env_rate_calc_chk #(
  parameter int NUM_SLOTS   = 24,
  parameter int BANK0_SLOTS = 3,
  parameter int BASE_W      = 5,
  parameter int RATE_W      = 6,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd,
  input logic [BASE_W-1:0] base,
  input logic [SLOT_W-1:0] slot_o,
  input logic              bank_o,
  input logic [SLOT_W-1:0] reg_idx_o,
  input logic [RATE_W-1:0] rate_o,
  input logic              rate_valid_o,
  input logic              rate_ready_i
);

  logic [SLOT_W-1:0] nxt_slot;
  assign nxt_slot = (slot_o == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_o + 1'b1;

  // R2: a result appears after every visit, and visits never abut
  assert_valid_after_visit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> rate_valid_o);
  assert_visit_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  // R3: slot pointer steps by one, wrapping
  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> slot_o == $past(nxt_slot));
  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o < SLOT_W'(NUM_SLOTS));

  // R4: bank/index address points back to the serviced slot
  assert_bank_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_o ? (reg_idx_o + SLOT_W'(BANK0_SLOTS) == slot_o) : (reg_idx_o == slot_o));

  // R10: zero base rate yields zero
  assert_zero_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && base == '0) |=> (rate_o == '0));

  // R11: held result stays put under back-pressure
  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid_o && !rate_ready_i) |=> rate_valid_o);
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid_o && !rate_ready_i && !upd) |=> $stable(rate_o));
  assert_drop_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_valid_o && rate_ready_i && !upd) |=> !rate_valid_o);

endmodule

bind env_rate_calc env_rate_calc_chk #(
  .NUM_SLOTS(NUM_SLOTS), .BANK0_SLOTS(BANK0_SLOTS), .BASE_W(BASE_W), .RATE_W(RATE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd_w), .base(base_w),
  .slot_o(slot_o), .bank_o(bank_o), .reg_idx_o(reg_idx_o),
  .rate_o(rate_o), .rate_valid_o(rate_valid_o), .rate_ready_i(rate_ready_i)
);

// File: tb/env_rate_calc_bench.sv
module env_rate_calc_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] slot_o, reg_idx_o;
  logic       bank_o;
  logic [1:0] phase_i, ks_sel_i;
  logic [4:0] keycode_i, atk_rate_i, dec_rate_i, sus_rate_i;
  logic [3:0] rel_rate_i;
  logic [5:0] rate_o;
  logic       rate_valid_o;
  logic       rate_ready_i = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc_n = 0;
  int exp_slot = 0;
  int last_valid = -1;

  // per-slot register model contents
  logic [1:0] m_ph  [24];
  logic [1:0] m_ks  [24];
  logic [4:0] m_kc  [24];
  logic [4:0] m_atk [24];
  logic [4:0] m_dec [24];
  logic [4:0] m_sus [24];
  logic [3:0] m_rel [24];

  always #10 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  env_rate_calc u_env_rate_calc (
    .clk(clk), .rst_n(rst_n), .slot_o(slot_o), .bank_o(bank_o),
    .reg_idx_o(reg_idx_o), .phase_i(phase_i), .keycode_i(keycode_i),
    .ks_sel_i(ks_sel_i), .atk_rate_i(atk_rate_i), .dec_rate_i(dec_rate_i),
    .sus_rate_i(sus_rate_i), .rel_rate_i(rel_rate_i), .rate_o(rate_o),
    .rate_valid_o(rate_valid_o), .rate_ready_i(rate_ready_i)
  );

  // register file answers only by bank and index (R4)
  logic [4:0] rslot;
  logic       rok;
  always_comb begin
    rslot = bank_o ? reg_idx_o + 5'd3 : reg_idx_o;
    rok   = bank_o ? (reg_idx_o < 5'd21) : (reg_idx_o < 5'd3);
  end
  assign atk_rate_i = rok ? m_atk[rslot] : 5'd0;
  assign dec_rate_i = rok ? m_dec[rslot] : 5'd0;
  assign sus_rate_i = rok ? m_sus[rslot] : 5'd0;
  assign rel_rate_i = rok ? m_rel[rslot] : 4'd0;
  assign ks_sel_i   = rok ? m_ks[rslot]  : 2'd0;
  assign phase_i    = (slot_o < 5'd24) ? m_ph[slot_o] : 2'd0;
  assign keycode_i  = (slot_o < 5'd24) ? m_kc[slot_o] : 5'd0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rate(input int s);
    int b, t, r;
    case (m_ph[s])
      2'd0: b = m_atk[s];
      2'd1: b = m_dec[s];
      2'd2: b = m_sus[s];
      default: b = m_rel[s] * 2 + 1;             // R6
    endcase
    t = m_kc[s] >> (3 - m_ks[s]);                // R7
    if (b == 0) return 0;                        // R10
    r = 2 * b + t;                               // R8
    return (r > 63) ? 63 : r;                    // R9
  endfunction

  // wait for the next result, check it against the model and the schedule
  task automatic take(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int w = 0;
      while (!rate_valid_o && w < 200) begin
        @(negedge clk);
        w++;
      end
      chk(rate_valid_o, "R2 result arrives", rate_valid_o, 1);
      if (last_valid >= 0)
        chk(cyc_n - last_valid == 72, "R2 visit spacing", cyc_n - last_valid, 72);
      last_valid = cyc_n;
      chk(rate_o == exp_rate(exp_slot), tag, rate_o, exp_rate(exp_slot));
      exp_slot = (exp_slot + 1) % 24;
      @(negedge clk);
      chk(!rate_valid_o, "R2 one-cycle strobe", rate_valid_o, 0);
    end
  endtask

  task automatic cfg_mix();
    for (int s = 0; s < 24; s++) begin
      m_ph[s]  = 2'(s % 4);
      m_ks[s]  = 2'((s / 4) % 4);
      m_kc[s]  = 5'((s * 13) % 32);
      m_atk[s] = 5'((s * 7 + 3) % 32);
      m_dec[s] = 5'((s * 5 + 1) % 32);
      m_sus[s] = 5'((s * 3 + 2) % 32);
      m_rel[s] = 4'((s * 11) % 16);
    end
  endtask

  task automatic t_reset();
    cfg_mix();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rate_valid_o == 0, "R1 valid low in reset", rate_valid_o, 0);
    chk(slot_o == 0, "R1 slot zero", slot_o, 0);
    chk(bank_o == 0, "R1 bank zero", bank_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rate_valid_o == 1, "R1 first visit at once", rate_valid_o, 1);
    chk(rate_o == exp_rate(0), "R1 slot 0 result", rate_o, exp_rate(0));
    last_valid = cyc_n;
    exp_slot = 1;
    @(negedge clk);
  endtask

  // R3 R4 R5 R6 R8: every phase and both banks over a full round
  task automatic t_phase_mix();
    take(24, "R5/R6/R8 mixed phases across R3 R4 order");
  endtask

  // R7: every key-scale setting with several keycodes
  task automatic t_keyscale();
    for (int s = 0; s < 24; s++) begin
      m_ph[s] = 2'd0; m_atk[s] = 5'd4;
      m_ks[s] = 2'(s % 4); m_kc[s] = 5'((s * 7 + 5) % 32);
    end
    take(24, "R7 keycode term");
  endtask

  // R9 saturation, R10 zero base, R6 smallest release
  task automatic t_sat_zero();
    for (int s = 0; s < 24; s++) begin
      m_kc[s] = 5'd31;
      case (s % 3)
        0: begin m_ph[s] = 2'd0; m_atk[s] = 5'd31; m_ks[s] = 2'd3; end
        1: begin m_ph[s] = 2'd1; m_dec[s] = 5'd0;  m_ks[s] = 2'd3; end
        default: begin m_ph[s] = 2'd3; m_rel[s] = 4'd0; m_ks[s] = 2'((s / 3) % 4); end
      endcase
    end
    take(24, "R9/R10/R6 limits");
  endtask

  // R11 hold under back-pressure, R12 overwrite by next visit
  task automatic t_backpressure();
    int s0;
    int w = 0;
    rate_ready_i = 1'b0;
    while (!rate_valid_o && w < 200) begin
      @(negedge clk);
      w++;
    end
    s0 = exp_slot;
    chk(rate_o == exp_rate(s0), "R11 held value", rate_o, exp_rate(s0));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(rate_valid_o == 1, "R11 valid held", rate_valid_o, 1);
      chk(rate_o == exp_rate(s0), "R11 value stable", rate_o, exp_rate(s0));
    end
    repeat (55) @(negedge clk);
    chk(rate_valid_o == 1, "R12 valid after overwrite", rate_valid_o, 1);
    chk(rate_o == exp_rate((s0 + 1) % 24), "R12 overwritten value",
        rate_o, exp_rate((s0 + 1) % 24));
    rate_ready_i = 1'b1;
    @(negedge clk);
    chk(rate_valid_o == 0, "R11 drop after handshake", rate_valid_o, 0);
    exp_slot = (s0 + 2) % 24;
    last_valid = -1;
    take(2, "R11 stream resumes");
  endtask

  initial begin
    #(20 * 50000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_phase_mix();
    t_keyscale();
    t_sat_zero();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule